// File: doc/BRIEF.md
# Symmetric Gate-Command Glitch Filter

This block cleans one digital gate command before it reaches the interlock and output stages of a power-switch driver. Burst noise on the command lines can put narrow spikes onto the signal. These spikes can be extra on-pulses or brief dropouts inside a long on-command. The filter removes both kinds in the same way, so that such noise cannot toggle the power switch.

The raw command first passes through a synchroniser clocked by the system clock. A counter then measures how many consecutive cycles the synchronised level has differed from the filtered output. The output takes the new level only when that run reaches the qualification length. If the input returns to the output level before then, the run is discarded. Each edge that passes is therefore delayed by a fixed time. Any pulse shorter than the qualification length disappears, whichever its polarity.

With a 40 MHz clock and the default length of 28 cycles, the threshold is 700 ns. That sits inside the tolerated band: pulses below 625 ns are always rejected, pulses above 750 ns always pass, and pulses in between may go either way. The reset is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `glitch_reject_filter`

## Requirements
- R1: While rst_n is low, cmd_filt is 0 (off). This holds even when reset is asserted while the output is 1. After release, cmd_filt stays 0 until a high level has qualified.
- R2: When cmd_raw rises and then stays 1, cmd_filt becomes 1 exactly SYNC_STAGES+QUAL_CYCLES clock cycles later (30 with defaults). A high pulse of QUAL_CYCLES cycles or longer (28 or more) always reaches the output.
- R3: A high pulse on cmd_raw that is shorter than QUAL_CYCLES cycles (27 or fewer) never makes cmd_filt 1 while the output is 0.
- R4: A low dropout on cmd_raw that is shorter than QUAL_CYCLES cycles never makes cmd_filt 0 while the output is 1.
- R5: When cmd_raw falls and then stays 0, cmd_filt becomes 0 exactly SYNC_STAGES+QUAL_CYCLES cycles later. A low pulse of QUAL_CYCLES cycles or longer always passes.
- R6: A run of differing cycles restarts from zero whenever the synchronised input equals the output again. Several short runs that are separated by single-cycle returns never add up to a qualification.
- R7: cmd_filt changes only at the end of a complete qualification run. While the input stays at the output level, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_raw | input | 1 | Unfiltered gate command, asynchronous to clk |
| cmd_filt | output | 1 | Filtered gate command, 1 = switch on |

## Verification
The two functions that can land in the same cycle are the clearing of the run counter and the completion of a qualification. This happens when the input falls back to the output level on exactly the cycle the count would have expired. The bench provokes it with pulses of QUAL_CYCLES-1 and QUAL_CYCLES cycles in both polarities. Its verdict rests on whether the output ever shows the pulse level and on the exact edge latency. Interrupted runs and a reset applied while the output is high complete the picture.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Default qualification: 28 cycles of a 40 MHz clock = 700 ns
  localparam int unsigned GF_QUAL_DEFAULT = 28;
  localparam int unsigned GF_SYNC_DEFAULT = 2;
  localparam int unsigned GF_RST_DEFAULT  = 2;

  function automatic int unsigned gf_cnt_width(input int unsigned qual);
    int unsigned w;
    w = 1;
    while ((1 << w) < qual) w++;
    return w;
  endfunction
endpackage

// File: rtl/gf_reset_sync.sv
module gf_reset_sync #(
  parameter int unsigned STAGES = gf_pkg::GF_RST_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gf_sync_chain.sv
module gf_sync_chain #(
  parameter int unsigned STAGES = gf_pkg::GF_SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_d[g] = d_async;
      end else begin : g_rest
        assign stage_d[g] = stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gf_qual_counter.sv
module gf_qual_counter #(
  parameter int unsigned QUAL_CYCLES = gf_pkg::GF_QUAL_DEFAULT,
  localparam int unsigned CNT_W = gf_pkg::gf_cnt_width(QUAL_CYCLES),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_sync,
  input  logic lvl_out,
  output logic qual_done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             differ;
  logic             cnt_en;

  always_comb begin
    differ    = (lvl_sync != lvl_out);
    qual_done = differ && (cnt_q == LAST);
    cnt_en    = differ || (cnt_q != '0);
    if (!differ || qual_done) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: an equal sample discards the run
  p_run_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sync == lvl_out) |=> (cnt_q == '0));
  // R7: count never exceeds the qualification window
  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R2: a completed run restarts the count
  p_done_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_done |=> (cnt_q == '0));
endmodule

// File: rtl/gf_out_stage.sv
module gf_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_done,
  output logic lvl_out
);
  logic out_q;
  logic out_d;

  always_comb begin
    out_d = qual_done ? ~out_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= 1'b0;
    else if (qual_done) out_q <= out_d;
  end

  assign lvl_out = out_q;

  // R7: output moves only after the counter reports a full run
  p_change_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(qual_done));
endmodule

// File: rtl/glitch_reject_filter.sv
module glitch_reject_filter #(
  parameter int unsigned QUAL_CYCLES = gf_pkg::GF_QUAL_DEFAULT,
  parameter int unsigned SYNC_STAGES = gf_pkg::GF_SYNC_DEFAULT,
  parameter int unsigned RST_STAGES  = gf_pkg::GF_RST_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_raw,
  output logic cmd_filt
);
  logic rst_sync_n;
  logic lvl_sync;
  logic lvl_out;
  logic qual_done;

  gf_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gf_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (cmd_raw),
    .q_sync  (lvl_sync)
  );

  gf_qual_counter #(.QUAL_CYCLES(QUAL_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lvl_sync  (lvl_sync),
    .lvl_out   (lvl_out),
    .qual_done (qual_done)
  );

  gf_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .qual_done (qual_done),
    .lvl_out   (lvl_out)
  );

  assign cmd_filt = lvl_out;

  // R7: input at output level keeps the output steady
  p_hold_when_equal_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_sync == lvl_out) |=> $stable(lvl_out));
  // R1: reset internals force the off state
  p_off_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_sync_n) |-> !cmd_filt);
endmodule

// File: tb/sim_glitch_reject_filter.sv
module sim_glitch_reject_filter;
  localparam int unsigned QUAL = 28;
  localparam int unsigned SYNC = 2;
  localparam int unsigned LAT  = QUAL + SYNC;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_raw;
  logic cmd_filt;
  int   checks = 0;
  int   errs   = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  glitch_reject_filter #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_raw(cmd_raw), .cmd_filt(cmd_filt)
  );

  // {base level, pulse width, expect pass}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'd27, 1'b0},  // R3
    {1'b0, 8'd28, 1'b1},  // R2
    {1'b0, 8'd5,  1'b0},  // R3
    {1'b0, 8'd60, 1'b1},  // R2
    {1'b1, 8'd27, 1'b0},  // R4
    {1'b1, 8'd28, 1'b1},  // R5
    {1'b1, 8'd1,  1'b0},  // R4
    {1'b1, 8'd40, 1'b1}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic lvl);
    @(negedge clk);
    cmd_raw = lvl;
    repeat (LAT + 10) @(negedge clk);
  endtask

  task automatic latency(input logic lvl, input string req);
    int n;
    n = 0;
    @(negedge clk);
    cmd_raw = lvl;
    while (cmd_filt != lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == LAT, req, n, LAT);
  endtask

  task automatic run_pattern(input int hi_len, input int lo_len, input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < hi_len; i++) begin
        @(negedge clk); cmd_raw = 1'b1;
      end
      for (int i = 0; i < lo_len; i++) begin
        @(negedge clk); cmd_raw = 1'b0;
      end
    end
  endtask

  initial begin
    int seen;
    rst_n   = 1'b0;
    cmd_raw = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_filt == 1'b0, "R1 reset state", cmd_filt, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(cmd_filt == 1'b0, "R1 after release", cmd_filt, 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic base;
      int   w;
      bit   pass;
      base = VEC[v][9];
      w    = int'(VEC[v][8:1]);
      pass = VEC[v][0];
      settle(base);
      check(cmd_filt == base, "R2/R5 settle", cmd_filt, base);
      seen = 0;
      for (int i = 0; i < w + LAT + 20; i++) begin
        @(negedge clk);
        if (cmd_filt == ~base) seen = 1;
        cmd_raw = (i < w) ? ~base : base;
      end
      if (base == 1'b0)
        check(seen == int'(pass), pass ? "R2 high pulse pass" : "R3 high pulse reject", seen, pass);
      else
        check(seen == int'(pass), pass ? "R5 low pulse pass" : "R4 low dropout reject", seen, pass);
      check(cmd_filt == base, "R7 return to base", cmd_filt, base);
    end

    // exact latency both edges
    settle(1'b0);
    latency(1'b1, "R2 rise latency");
    latency(1'b0, "R5 fall latency");

    // interrupted runs do not accumulate
    settle(1'b0);
    seen = 0;
    fork
      run_pattern(QUAL - 1, 1, 6);
      repeat ((QUAL) * 6 + 2) begin
        @(negedge clk);
        if (cmd_filt) seen = 1;
      end
    join
    repeat (LAT) @(negedge clk);
    check(seen == 0 && cmd_filt == 1'b0, "R6 interrupted high runs", seen, 0);

    settle(1'b1);
    seen = 0;
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < QUAL; i++) begin
        @(negedge clk);
        if (!cmd_filt) seen = 1;
        cmd_raw = (i == QUAL - 1) ? 1'b1 : 1'b0;
      end
    end
    @(negedge clk); cmd_raw = 1'b1;
    repeat (LAT) begin
      @(negedge clk);
      if (!cmd_filt) seen = 1;
    end
    check(seen == 0, "R6 interrupted low runs", seen, 0);

    // hold while equal
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (!cmd_filt) seen = 1;
    end
    check(seen == 0, "R7 hold when equal", seen, 0);

    // reset while output high
    check(cmd_filt == 1'b1, "R1 pre-reset high", cmd_filt, 1);
    #2 rst_n = 1'b0;
    #1;
    check(cmd_filt == 1'b0, "R1 async reset clears", cmd_filt, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_filt == 1'b0, "R1 off after release", cmd_filt, 0);
    repeat (LAT + 4) @(negedge clk);
    check(cmd_filt == 1'b1, "R2 requalify after reset", cmd_filt, 1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule